// File: doc/BRIEF.md
# Paged Flash Erase-Program Controller

This block sequences erase and program operations on an on-chip non-volatile code array. The array is split into 1 KB sectors, and each sector is split into 64-byte pages. Software fills a 64-lane page buffer one byte at a time. Every lane that is written is marked as loaded. Software then issues one of five commands against an address: program, erase-program, page erase, sector erase or chip erase. A busy flag and a one-cycle done pulse show when the operation starts and when it ends.

Once a command is accepted, the controller walks the target range one byte per cycle. It drives a simple array port with an address, write data, a write strobe and an erase strobe. The array applies the erase strobe first, which sets the byte to 0xFF. It then applies the write strobe, which ANDs the write data into the byte. Asserting both strobes in one cycle therefore stores the data exactly. Operation time comes from an internal cycle counter, and software cannot shorten it.

Each sector has a security bit. A secured sector cannot be modified and cannot be read through the code-read port. A command is rejected if it targets a secured sector, if its code is unknown, or if it arrives while the controller is busy. A rejection raises an error flag and leaves the array unchanged.

Top module: `flash_pgm_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `arr_we`, `arr_erase` and `rd_ok` are all 0.
- R2: Page erase (`cmd_code` 3) sets every byte of the 64-byte page that contains `cmd_addr` (page = `cmd_addr[ADDR_W-1:6]`) to 0xFF. All other bytes are left unchanged.
- R3: Sector erase (`cmd_code` 4) sets every byte of the 1 KB sector that contains `cmd_addr` (sector = `cmd_addr[ADDR_W-1:10]`) to 0xFF. All other bytes are left unchanged.
- R4: Chip erase (`cmd_code` 5) sets every byte of the array to 0xFF. It is accepted only when no sector is secured.
- R5: Program (`cmd_code` 1) changes only the loaded lanes. For each loaded lane i, byte page_base+i becomes its old value ANDed with the buffer byte of lane i. Unloaded lanes are left unchanged.
- R6: Erase-program (`cmd_code` 2) sets byte page_base+i to exactly the buffer byte of lane i, for every loaded lane i. Every other byte of the page keeps its old value.
- R7: `busy` rises in the cycle after an accepted `cmd_go`. It stays high for max(T, N+1) cycles. T is `LONG_CYC` for code 2 and `SHORT_CYC` for every other code. N is the number of bytes walked: 64 for codes 1 to 3, 1024 for code 4, and the whole array for code 5.
- R8: `done` is high for exactly one cycle: the first cycle in which `busy` is low again after an operation.
- R9: A `cmd_go` is rejected if the controller is busy, if the code is 0, 6 or 7, or if the target sector is secured (`sec_lock[sector]` = 1). For code 5, any secured sector causes rejection. A rejection sets `err` in the next cycle and leaves the array and `busy` unchanged. The next accepted command clears `err`.
- R10: The loaded-lane mask is cleared when any operation completes and when `pb_clr` is asserted while idle. A rejected command leaves it unchanged.
- R11: While `busy` is high, `pb_wr` and `pb_clr` have no effect on the page buffer.
- R12: One cycle after `rd_en`, `rd_data` holds the array byte at `rd_addr` and `rd_ok` is 1, provided that sector is not secured. If the sector is secured, `rd_data` is 0 and `rd_ok` is 0.
- R13: The array strobes are asserted only while `busy` is high. They are asserted only at addresses inside the range of the running command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pb_wr | input | 1 | Write one page-buffer lane |
| pb_idx | input | 6 | Lane index for `pb_wr` |
| pb_data | input | 8 | Lane data for `pb_wr` |
| pb_clr | input | 1 | Clear the loaded-lane mask |
| cmd_go | input | 1 | Issue a command |
| cmd_code | input | 3 | 1 program, 2 erase-program, 3 page erase, 4 sector erase, 5 chip erase |
| cmd_addr | input | ADDR_W | Target byte address (low bits ignored as needed) |
| sec_lock | input | N_SECT | Per-sector security bits |
| rd_en | input | 1 | Code-read request |
| rd_addr | input | ADDR_W | Code-read address |
| rd_data | output | 8 | Code-read data (registered) |
| rd_ok | output | 1 | Code-read permitted |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last command was rejected |
| arr_addr | output | ADDR_W | Array modify address |
| arr_wdata | output | 8 | Array write data |
| arr_we | output | 1 | Array write strobe (AND into byte) |
| arr_erase | output | 1 | Array erase strobe (byte to 0xFF) |
| arr_raddr | output | ADDR_W | Array read address |
| arr_rdata | input | 8 | Array read data |

## Verification
On every cycle, the assertions check the following. The strobes appear only while busy and only inside the target range. `done` is a single pulse that coincides with the fall of `busy`. A busy-time command always raises `err`. A read of a secured sector is always refused. The loaded-lane mask empties on a clear. The exact content of the array after each command can only be shown by the bench scenarios, which compare a full image of the array against a reference model. The same holds for operation length, for lane masks that survive a rejection, and for buffer writes that are ignored in the middle of an operation.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERPROG = 3'd2,
    OP_PERASE = 3'd3,
    OP_SERASE = 3'd4,
    OP_CERASE = 3'd5
  } fpc_op_e;
endpackage

// File: rtl/fpc_page_buf.sv
module fpc_page_buf #(
  parameter int PAGE_BYTES = 64,
  parameter int LANE_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [LANE_W-1:0] wr_idx,
  input  logic [7:0]        wr_data,
  input  logic              clr,
  input  logic [LANE_W-1:0] rd_idx,
  output logic [7:0]        rd_data,
  output logic              rd_vld
);
  logic [7:0]            lane_mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;

  // data lanes: plain RAM, no reset
  always_ff @(posedge clk) begin
    if (wr_en) lane_mem[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loaded <= '0;
    end else begin
      if (clr)   loaded <= '0;
      if (wr_en) loaded[wr_idx] <= 1'b1;
    end
  end

  assign rd_data = lane_mem[rd_idx];
  assign rd_vld  = loaded[rd_idx];

  // R10: a clear leaves no lane marked
  p_clr_empties_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && !wr_en) |=> (loaded == '0));
  // R10: a written lane is marked
  p_load_marks_r10: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> loaded[$past(wr_idx)]);
endmodule

// File: rtl/fpc_guard.sv
module fpc_guard
  import fpc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int PAGE_LSB = 6,
  parameter int SECT_LSB = 10,
  parameter int N_SECT   = 4
) (
  input  logic              cmd_go,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              busy,
  input  logic [N_SECT-1:0] sec_lock,
  output logic              accept,
  output logic              reject,
  output fpc_op_e           op,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] last
);
  logic known;
  logic blocked;

  always_comb begin
    known   = 1'b1;
    blocked = sec_lock[cmd_addr[ADDR_W-1:SECT_LSB]];
    op      = OP_NONE;
    base    = '0;
    last    = '0;
    case (cmd_code)
      3'd1, 3'd2, 3'd3: begin
        op   = fpc_op_e'(cmd_code);
        base = {cmd_addr[ADDR_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
        last = ADDR_W'((1 << PAGE_LSB) - 1);
      end
      3'd4: begin
        op   = OP_SERASE;
        base = {cmd_addr[ADDR_W-1:SECT_LSB], {SECT_LSB{1'b0}}};
        last = ADDR_W'((1 << SECT_LSB) - 1);
      end
      3'd5: begin
        op      = OP_CERASE;
        base    = '0;
        last    = '1;
        blocked = |sec_lock;
      end
      default: known = 1'b0;
    endcase
    accept = cmd_go & ~busy & known & ~blocked;
    reject = cmd_go & ~accept;
  end
endmodule

// File: rtl/fpc_sequencer.sv
module fpc_sequencer
  import fpc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int LANE_W    = 6,
  parameter int SHORT_CYC = 100000,
  parameter int LONG_CYC  = 200000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  fpc_op_e           start_op,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [ADDR_W-1:0] start_last,
  input  logic              lane_vld,
  input  logic [7:0]        lane_dat,
  output logic [LANE_W-1:0] lane_idx,
  output logic              busy,
  output logic              done,
  output logic              fin,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_erase
);
  localparam int MAXC  = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  fpc_op_e           op_q;
  logic [ADDR_W-1:0] base_q, last_q, idx_q;
  logic              walk_q;
  logic [CNT_W-1:0]  tmr_q, tgt_q;
  logic              is_prog, is_ers, is_eprog;

  assign is_eprog = (op_q == OP_ERPROG);
  assign is_prog  = (op_q == OP_PROG) || is_eprog;
  assign is_ers   = (op_q == OP_PERASE) || (op_q == OP_SERASE) || (op_q == OP_CERASE);
  assign lane_idx = idx_q[LANE_W-1:0];
  assign fin      = busy && !walk_q && (tmr_q >= tgt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      walk_q    <= 1'b0;
      op_q      <= OP_NONE;
      base_q    <= '0;
      last_q    <= '0;
      idx_q     <= '0;
      tmr_q     <= '0;
      tgt_q     <= '0;
      arr_addr  <= '0;
      arr_wdata <= '0;
      arr_we    <= 1'b0;
      arr_erase <= 1'b0;
    end else begin
      done      <= 1'b0;
      arr_we    <= 1'b0;
      arr_erase <= 1'b0;
      if (start) begin
        busy   <= 1'b1;
        op_q   <= start_op;
        base_q <= start_base;
        last_q <= start_last;
        idx_q  <= '0;
        walk_q <= 1'b1;
        tmr_q  <= '0;
        tgt_q  <= (start_op == OP_ERPROG) ? CNT_W'(LONG_CYC - 1) : CNT_W'(SHORT_CYC - 1);
      end else if (busy) begin
        if (tmr_q < tgt_q) tmr_q <= tmr_q + 1'b1;
        if (walk_q) begin
          arr_addr  <= base_q + idx_q;
          arr_wdata <= lane_dat;
          arr_we    <= is_prog & lane_vld;
          arr_erase <= is_ers | (is_eprog & lane_vld);
          idx_q     <= idx_q + 1'b1;
          if (idx_q == last_q) walk_q <= 1'b0;
        end
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R13: strobes only during an operation
  p_strobe_busy_r13: assert property (@(posedge clk) disable iff (rst)
    (arr_we || arr_erase) |-> busy);
  // R13: strobes stay inside the command's range
  p_strobe_range_r13: assert property (@(posedge clk) disable iff (rst)
    (arr_we || arr_erase) |-> ((arr_addr - base_q) <= last_q));
  // R8: single-cycle completion pulse
  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: busy only falls together with done
  p_fall_done_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
  // R7: an accepted command raises busy next cycle
  p_start_busy_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> (busy && !done));
endmodule

// File: rtl/flash_pgm_ctrl.sv
module flash_pgm_ctrl
  import fpc_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 64,
  parameter int SECT_BYTES = 1024,
  parameter int SHORT_CYC  = 100000,
  parameter int LONG_CYC   = 200000,
  localparam int LANE_W    = $clog2(PAGE_BYTES),
  localparam int SECT_LSB  = $clog2(SECT_BYTES),
  localparam int N_SECT    = 1 << (ADDR_W - SECT_LSB)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pb_wr,
  input  logic [LANE_W-1:0] pb_idx,
  input  logic [7:0]        pb_data,
  input  logic              pb_clr,
  input  logic              cmd_go,
  input  logic [2:0]        cmd_code,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [N_SECT-1:0] sec_lock,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              rd_ok,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata,
  output logic              arr_we,
  output logic              arr_erase,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata
);
  logic              accept, reject, fin, lane_vld, rd_lock;
  fpc_op_e           g_op;
  logic [ADDR_W-1:0] g_base, g_last;
  logic [LANE_W-1:0] lane_idx;
  logic [7:0]        lane_dat;

  fpc_guard #(
    .ADDR_W(ADDR_W), .PAGE_LSB(LANE_W), .SECT_LSB(SECT_LSB), .N_SECT(N_SECT)
  ) u_guard (
    .cmd_go(cmd_go), .cmd_code(cmd_code), .cmd_addr(cmd_addr), .busy(busy),
    .sec_lock(sec_lock), .accept(accept), .reject(reject), .op(g_op),
    .base(g_base), .last(g_last)
  );

  fpc_page_buf #(.PAGE_BYTES(PAGE_BYTES), .LANE_W(LANE_W)) u_buf (
    .clk(clk), .rst(rst), .wr_en(pb_wr & ~busy), .wr_idx(pb_idx),
    .wr_data(pb_data), .clr((pb_clr & ~busy) | fin), .rd_idx(lane_idx),
    .rd_data(lane_dat), .rd_vld(lane_vld)
  );

  fpc_sequencer #(
    .ADDR_W(ADDR_W), .LANE_W(LANE_W), .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .start(accept), .start_op(g_op),
    .start_base(g_base), .start_last(g_last), .lane_vld(lane_vld),
    .lane_dat(lane_dat), .lane_idx(lane_idx), .busy(busy), .done(done),
    .fin(fin), .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_we(arr_we),
    .arr_erase(arr_erase)
  );

  always_ff @(posedge clk) begin
    if (rst)         err <= 1'b0;
    else if (reject) err <= 1'b1;
    else if (accept) err <= 1'b0;
  end

  // code-read path, gated by sector security
  assign arr_raddr = rd_addr;
  assign rd_lock   = sec_lock[rd_addr[ADDR_W-1:SECT_LSB]];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      rd_ok   <= 1'b0;
    end else begin
      rd_ok <= rd_en & ~rd_lock;
      if (rd_en) rd_data <= rd_lock ? 8'h00 : arr_rdata;
    end
  end

  // R9: a command during an operation is flagged
  p_busy_reject_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && busy) |=> err);
  // R12: secured bytes never come out of the read port
  p_read_lock_r12: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_lock) |=> (!rd_ok && rd_data == 8'h00));
endmodule

// File: tb/tb_flash_pgm_ctrl.sv
module tb_flash_pgm_ctrl;
  localparam int AW    = 12;
  localparam int ARR   = 1 << AW;
  localparam int SHORT = 200;
  localparam int LONG  = 300;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pb_wr = 0, pb_clr = 0, cmd_go = 0, rd_en = 0;
  logic [5:0] pb_idx = 0;
  logic [7:0] pb_data = 0;
  logic [2:0] cmd_code = 0;
  logic [AW-1:0] cmd_addr = 0, rd_addr = 0;
  logic [3:0] sec_lock = 0;
  logic [7:0] rd_data, arr_wdata, arr_rdata;
  logic rd_ok, busy, done, err, arr_we, arr_erase;
  logic [AW-1:0] arr_addr, arr_raddr;

  int nchk = 0, nerr = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] init_val(int i);
    return 8'(i * 37 + 11) ^ 8'(i >> 3);
  endfunction

  // array model
  logic [7:0] mem [ARR];
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ARR; i++) mem[i] <= init_val(i);
    end else if (arr_we || arr_erase) begin
      mem[arr_addr] <= (arr_erase ? 8'hFF : mem[arr_addr]) & (arr_we ? arr_wdata : 8'hFF);
    end
  end
  assign arr_rdata = mem[arr_raddr];

  flash_pgm_ctrl #(.ADDR_W(AW), .SHORT_CYC(SHORT), .LONG_CYC(LONG)) dut (
    .clk(clk), .rst(rst), .pb_wr(pb_wr), .pb_idx(pb_idx), .pb_data(pb_data),
    .pb_clr(pb_clr), .cmd_go(cmd_go), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
    .sec_lock(sec_lock), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_ok(rd_ok), .busy(busy), .done(done), .err(err), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .arr_we(arr_we), .arr_erase(arr_erase),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata)
  );

  // reference state
  logic [7:0] ref_mem [ARR];
  logic [7:0] ref_buf [64];
  logic [63:0] ref_mask = '0;

  task automatic check(string tag, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic check_mem(string tag);
    int bad = 0, first = -1;
    for (int i = 0; i < ARR; i++)
      if (mem[i] !== ref_mem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    nchk++;
    if (bad != 0) begin
      nerr++;
      $display("FAIL %s array mismatches=%0d first_addr=%0h actual=%0h expected=%0h",
               tag, bad, first, mem[first], ref_mem[first]);
    end
  endtask

  function automatic int exp_busy(int code);
    int t = (code == 2) ? LONG : SHORT;
    int n = (code == 4) ? 1025 : (code == 5) ? ARR + 1 : 65;
    return (t > n) ? t : n;
  endfunction

  function automatic bit exp_ok(int code, int addr);
    if (code < 1 || code > 5) return 0;
    if (code == 5) return sec_lock == 0;
    return !sec_lock[addr >> 10];
  endfunction

  task automatic ref_apply(int code, int addr);
    int pb = addr & ~63;
    int sb = addr & ~1023;
    case (code)
      1: for (int i = 0; i < 64; i++) if (ref_mask[i]) ref_mem[pb+i] &= ref_buf[i];
      2: for (int i = 0; i < 64; i++) if (ref_mask[i]) ref_mem[pb+i] = ref_buf[i];
      3: for (int i = 0; i < 64; i++) ref_mem[pb+i] = 8'hFF;
      4: for (int i = 0; i < 1024; i++) ref_mem[sb+i] = 8'hFF;
      default: for (int i = 0; i < ARR; i++) ref_mem[i] = 8'hFF;
    endcase
    ref_mask = '0;
  endtask

  task automatic load(int lane, logic [7:0] d);
    pb_wr = 1; pb_idx = 6'(lane); pb_data = d;
    @(negedge clk);
    pb_wr = 0;
    ref_buf[lane] = d;
    ref_mask[lane] = 1'b1;
  endtask

  task automatic clear_buf();
    pb_clr = 1;
    @(negedge clk);
    pb_clr = 0;
    ref_mask = '0;
  endtask

  task automatic run_cmd(int code, int addr, string tag);
    bit ok = exp_ok(code, addr);
    int n;
    cmd_go = 1; cmd_code = 3'(code); cmd_addr = AW'(addr);
    @(negedge clk);
    cmd_go = 0;
    check({tag, " R9 err"}, err, !ok);
    if (ok) begin
      n = 1;
      while (busy && n < 10000) begin
        @(negedge clk);
        if (busy) n++;
      end
      check({tag, " R7 busy length"}, n, exp_busy(code));
      check({tag, " R8 done at end"}, done, 1);
      @(negedge clk);
      check({tag, " R8 done single"}, done, 0);
      ref_apply(code, addr);
    end else begin
      check({tag, " R9 stays idle"}, busy, 0);
    end
    check_mem(tag);
  endtask

  task automatic do_read(int addr);
    bit lk = sec_lock[addr >> 10];
    rd_en = 1; rd_addr = AW'(addr);
    @(negedge clk);
    rd_en = 0;
    check("R12 rd_ok", rd_ok, !lk);
    check("R12 rd_data", rd_data, lk ? 0 : ref_mem[addr]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd2024);
    for (int i = 0; i < ARR; i++) ref_mem[i] = init_val(i);
    for (int i = 0; i < 64; i++) ref_buf[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 strobes", {arr_we, arr_erase}, 0);
    check("R1 rd_ok", rd_ok, 0);
    check_mem("R1 array intact");

    // R2 page erase
    run_cmd(3, 'h0C7, "R2 page erase");
    // R5 program ANDs into loaded lanes only
    load(0, 8'h0F); load(9, 8'hF0); load(63, 8'h3C);
    run_cmd(1, 'h245, "R5 program");
    // R6 erase-program sets loaded lanes exactly
    load(1, 8'hA5); load(2, 8'h00); load(40, 8'hFF);
    run_cmd(2, 'h380, "R6 erase-program");
    // R10 mask empty after completion: erase-program with nothing loaded
    run_cmd(2, 'h380, "R10 empty after done");

    // R10 mask survives a rejection; R9 secured sector
    sec_lock = 4'b0010;
    load(2, 8'h11);
    run_cmd(1, 'h410, "R9 locked sector");
    sec_lock = 4'b0000;
    run_cmd(2, 'h810, "R10 mask kept after reject");
    // R10 explicit clear
    load(5, 8'h00); load(6, 8'h00);
    clear_buf();
    run_cmd(1, 'hC00, "R10 clear");

    // R9 unknown codes
    run_cmd(0, 'h100, "R9 code0");
    run_cmd(7, 'h100, "R9 code7");
    run_cmd(6, 'h100, "R9 code6");

    // R9/R11 disturbances while busy
    load(10, 8'h5A); load(63, 8'hA5);
    cmd_go = 1; cmd_code = 3'd2; cmd_addr = AW'('h640);
    @(negedge clk);
    cmd_go = 0;
    check("R11 busy started", busy, 1);
    cmd_go = 1; cmd_code = 3'd3; cmd_addr = AW'('h000);
    @(negedge clk);
    cmd_go = 0;
    check("R9 busy reject err", err, 1);
    check("R9 busy kept", busy, 1);
    pb_wr = 1; pb_idx = 6'd63; pb_data = 8'h00;
    @(negedge clk);
    pb_wr = 0; pb_clr = 1;
    @(negedge clk);
    pb_clr = 0;
    while (busy) @(negedge clk);
    @(negedge clk);
    ref_apply(2, 'h640);
    check_mem("R11 buffer untouched while busy");
    check("R9 err held until accept", err, 1);

    // R3 sector erase, R4 chip erase
    run_cmd(4, 'h7FF, "R3 sector erase");
    check("R9 err cleared by accept", err, 0);
    sec_lock = 4'b1000;
    run_cmd(5, 'h000, "R4 chip erase locked");
    do_read('hC33);
    do_read('h033);
    sec_lock = 4'b0000;
    load(3, 8'h12);
    run_cmd(2, 'h000, "R6 before chip");
    run_cmd(5, 'h123, "R4 chip erase");
    do_read('hC33);

    // random mix
    for (int it = 0; it < 36; it++) begin
      int r, code, addr, k;
      if ($urandom % 4 == 0) sec_lock = 4'($urandom & $urandom);
      if ($urandom % 5 == 0) clear_buf();
      k = $urandom % 9;
      for (int j = 0; j < k; j++) load($urandom % 64, 8'($urandom));
      r = $urandom % 40;
      if (r < 13) code = 1;
      else if (r < 26) code = 2;
      else if (r < 33) code = 3;
      else if (r < 36) code = 4;
      else if (r < 37) code = 5;
      else code = (r == 37) ? 0 : (r == 38) ? 6 : 7;
      addr = $urandom % ARR;
      case (code)
        1: run_cmd(code, addr, "R5 random program");
        2: run_cmd(code, addr, "R6 random erase-program");
        3: run_cmd(code, addr, "R2 random page erase");
        4: run_cmd(code, addr, "R3 random sector erase");
        5: run_cmd(code, addr, "R4 random chip erase");
        default: run_cmd(code, addr, "R9 random bad code");
      endcase
      do_read($urandom % ARR);
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule